// File: doc/BRIEF.md
# LCD Vertical Frame Timing Generator

This block steps each display frame through three vertical phases: active lines, a front porch of blank lines, and a sync interval. It advances only when a one-cycle line strobe arrives from the horizontal timing unit. It reports the current row index, a flag that marks rows carrying pixel data, a frame-sync output, and a one-cycle marker at the start of each frame.

Three fields set the frame shape. Each is held in a snapshot that is reloaded only as a new frame begins, so software may rewrite them at any time without tearing the frame in progress. The row-count field and the sync-width field are stored as the count minus one. The porch field is stored as the plain count, and zero is a legal value.

In active-matrix (TFT) mode the sync interval drives the frame-sync output high. In passive (STN) mode the sync interval still inserts the same number of extra line periods, but the frame-sync output stays low. With the dual-panel flag set, the row count describes each half of the screen. Both halves are scanned together, so the active phase has the same length as in single-panel mode.

Top module: `vert_frame_timer`

## Requirements
- R1: After a synchronous active-low reset: the phase is active, `line_idx` is 0, `line_valid` is 1, and `frame_pulse` and `frame_start` are 0.
- R2: The active phase lasts `cfg_lines`+1 line strobes. During it `line_idx` runs 0,1,…,`cfg_lines`, one step per strobe. `line_valid` is 1 only in this phase, and `line_idx` reads 0 outside it.
- R3: The porch phase follows the last active line and lasts exactly `cfg_porch` strobes. A value of 0 skips the porch and goes directly to the sync phase.
- R4: The sync phase lasts `cfg_sync`+1 strobes. In TFT mode (`passive_mode`=0), `frame_pulse` is 1 for exactly that phase and 0 at all other times.
- R5: In passive mode (`passive_mode`=1), the sync phase still takes `cfg_sync`+1 strobes with `line_valid` low, and `frame_pulse` stays 0.
- R6: Outputs change only in the clock cycle after a clock edge at which `line_tick` was 1. The only exception is `frame_start` returning to 0.
- R7: `cfg_lines`, `cfg_porch`, `cfg_sync` and `passive_mode` are sampled during reset and at the edge that ends a sync phase. Changes at any other time have no effect until the next frame.
- R8: `frame_start` is 1 for exactly one cycle, on entry to active line 0 after a sync phase. It is not raised by reset.
- R9: With `dual_panel`=1, the active phase still lasts `cfg_lines`+1 strobes, because the field counts the lines of each half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_tick | input | 1 | One-cycle strobe per line period |
| passive_mode | input | 1 | 0 = TFT (sync pulse driven), 1 = STN (sync lines inserted, no pulse) |
| dual_panel | input | 1 | Row count is per half screen |
| cfg_lines | input | 10 | Active rows minus one |
| cfg_porch | input | 8 | Front porch line count (0–255) |
| cfg_sync | input | 6 | Sync lines minus one |
| frame_pulse | output | 1 | Vertical sync output (TFT only) |
| line_valid | output | 1 | High during active rows |
| line_idx | output | 10 | Current active row, 0 outside the active phase |
| frame_start | output | 1 | One-cycle strobe on entry to row 0 |

## Verification
A wrong phase or count value becomes visible one cycle after the next line strobe. It shows as a `line_valid` edge, a `line_idx` step or a `frame_pulse` edge that falls on the wrong strobe. The bench therefore compares every output after every strobe against a count of strobes since frame start. A stale or early-loaded configuration snapshot shows only when a frame ends, as a frame whose length matches the wrong settings. For this reason the inputs are changed in mid-frame and checked over several frame boundaries.

// File: rtl/vft_pkg.sv
// Package: shared types for the vertical frame timer.
// Assumes: the three phases fit a 2-bit encoding.
package vft_pkg;
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_PORCH  = 2'd1,
        PH_SYNC   = 2'd2
    } vphase_t;
endpackage

// File: rtl/vft_cfg_latch.sv
// Module: holds the frame configuration snapshot.
// Assumes: load is high only on the edge that ends a frame; the snapshot is
// also taken while reset is asserted so the first frame has valid settings.
module vft_cfg_latch #(
    parameter int LINE_W  = 10,
    parameter int PORCH_W = 8,
    parameter int SYNC_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               passive_in,
    input  logic [LINE_W-1:0]  lines_in,
    input  logic [PORCH_W-1:0] porch_in,
    input  logic [SYNC_W-1:0]  sync_in,
    output logic               passive_q,
    output logic [LINE_W-1:0]  lines_q,
    output logic [PORCH_W-1:0] porch_q,
    output logic [SYNC_W-1:0]  sync_q
);
    // Purpose: capture the live fields during reset or at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            passive_q <= passive_in;
            lines_q   <= lines_in;
            porch_q   <= porch_in;
            sync_q    <= sync_in;
        end
    end
endmodule

// File: rtl/vft_phase_ctrl.sv
// Module: phase sequencer and shared line counter.
// Assumes: configuration inputs stay constant within a frame; the counter
// width covers the widest of the three fields.
module vft_phase_ctrl
    import vft_pkg::*;
#(
    parameter int LINE_W  = 10,
    parameter int PORCH_W = 8,
    parameter int SYNC_W  = 6,
    localparam int CNT_W  = (LINE_W > PORCH_W) ?
                            ((LINE_W > SYNC_W) ? LINE_W : SYNC_W) :
                            ((PORCH_W > SYNC_W) ? PORCH_W : SYNC_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_tick,
    input  logic [LINE_W-1:0]  lines,
    input  logic [PORCH_W-1:0] porch,
    input  logic [SYNC_W-1:0]  sync,
    output vphase_t            phase,
    output logic [CNT_W-1:0]   cnt,
    output logic               wrap
);
    logic [CNT_W-1:0] lines_end;
    logic [CNT_W-1:0] porch_end;
    logic [CNT_W-1:0] sync_end;
    logic             porch_none;
    vphase_t          phase_d;
    logic [CNT_W-1:0] cnt_d;

    // Purpose: widen the fields to counter width and form the terminal counts.
    always_comb begin
        lines_end  = CNT_W'(lines);
        porch_end  = CNT_W'(porch) - CNT_W'(1);
        sync_end   = CNT_W'(sync);
        porch_none = (porch == '0);
    end

    // Purpose: end of frame, i.e. the last sync line closed by a strobe.
    assign wrap = line_tick && (phase == PH_SYNC) && (cnt == sync_end);

    // Purpose: next-state logic for the phase and the counter.
    always_comb begin
        phase_d = phase;
        cnt_d   = cnt;
        if (line_tick) begin
            cnt_d = cnt + CNT_W'(1);
            unique case (phase)
                PH_ACTIVE: if (cnt == lines_end) begin
                    cnt_d   = '0;
                    phase_d = porch_none ? PH_SYNC : PH_PORCH;
                end
                PH_PORCH: if (cnt == porch_end) begin
                    cnt_d   = '0;
                    phase_d = PH_SYNC;
                end
                PH_SYNC: if (cnt == sync_end) begin
                    cnt_d   = '0;
                    phase_d = PH_ACTIVE;
                end
                default: begin
                    cnt_d   = '0;
                    phase_d = PH_ACTIVE;
                end
            endcase
        end
    end

    // Purpose: phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_ACTIVE;
            cnt   <= '0;
        end else begin
            phase <= phase_d;
            cnt   <= cnt_d;
        end
    end
endmodule

// File: rtl/vft_out_stage.sv
// Module: turns phase and counter into the port-level signals.
// Assumes: wrap is a single-cycle pulse from the sequencer.
module vft_out_stage
    import vft_pkg::*;
#(
    parameter int LINE_W = 10,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  vphase_t           phase,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              passive,
    output logic              frame_pulse,
    output logic              line_valid,
    output logic [LINE_W-1:0] line_idx,
    output logic              frame_start
);
    // Purpose: decode the phase into the row flag, row index and sync output.
    always_comb begin
        line_valid  = (phase == PH_ACTIVE);
        line_idx    = line_valid ? cnt[LINE_W-1:0] : '0;
        frame_pulse = (phase == PH_SYNC) && !passive;
    end

    // Purpose: one-cycle start marker aligned with entry to row 0.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_start <= 1'b0;
        else        frame_start <= wrap;
    end
endmodule

// File: rtl/vert_frame_timer.sv
// Module: top of the vertical frame timer.
// Assumes: line_tick is one cycle wide and comes from the horizontal unit;
// dual-panel scanning drives both halves at once, so the row field is per half.
module vert_frame_timer
    import vft_pkg::*;
#(
    parameter int LINE_W  = 10,
    parameter int PORCH_W = 8,
    parameter int SYNC_W  = 6,
    localparam int CNT_W  = (LINE_W > PORCH_W) ?
                            ((LINE_W > SYNC_W) ? LINE_W : SYNC_W) :
                            ((PORCH_W > SYNC_W) ? PORCH_W : SYNC_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_tick,
    input  logic               passive_mode,
    input  logic               dual_panel,
    input  logic [LINE_W-1:0]  cfg_lines,
    input  logic [PORCH_W-1:0] cfg_porch,
    input  logic [SYNC_W-1:0]  cfg_sync,
    output logic               frame_pulse,
    output logic               line_valid,
    output logic [LINE_W-1:0]  line_idx,
    output logic               frame_start
);
    logic               passive_q;
    logic [LINE_W-1:0]  lines_q;
    logic [PORCH_W-1:0] porch_q;
    logic [SYNC_W-1:0]  sync_q;
    vphase_t            phase;
    logic [CNT_W-1:0]   cnt;
    logic               wrap;

    vft_cfg_latch #(.LINE_W(LINE_W), .PORCH_W(PORCH_W), .SYNC_W(SYNC_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(wrap),
        .passive_in(passive_mode), .lines_in(cfg_lines),
        .porch_in(cfg_porch), .sync_in(cfg_sync),
        .passive_q(passive_q), .lines_q(lines_q),
        .porch_q(porch_q), .sync_q(sync_q)
    );

    vft_phase_ctrl #(.LINE_W(LINE_W), .PORCH_W(PORCH_W), .SYNC_W(SYNC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
        .lines(lines_q), .porch(porch_q), .sync(sync_q),
        .phase(phase), .cnt(cnt), .wrap(wrap)
    );

    vft_out_stage #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .phase(phase), .cnt(cnt),
        .passive(passive_q), .frame_pulse(frame_pulse),
        .line_valid(line_valid), .line_idx(line_idx), .frame_start(frame_start)
    );
endmodule

// File: rtl/vft_checker.sv
// Module: property checker bound to the vertical frame timer.
// Assumes: lines_q and passive_q are the snapshot registers of the top.
module vft_checker #(
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_tick,
    input logic              dual_panel,
    input logic              passive_q,
    input logic [LINE_W-1:0] lines_q,
    input logic              frame_pulse,
    input logic              line_valid,
    input logic [LINE_W-1:0] line_idx,
    input logic              frame_start
);
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (line_idx <= lines_q));
    a_r2_idx_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !line_valid |-> (line_idx == '0));
    a_r4_pulse_blank: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> !line_valid);
    a_r5_passive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        passive_q |-> !frame_pulse);
    a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> ($stable(line_idx) && $stable(line_valid) && $stable(frame_pulse)));
    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
    a_r8_start_row0: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (line_valid && line_idx == '0));
    a_r8_start_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(line_tick));
    a_r9_dual_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_panel && line_valid) |-> (line_idx <= lines_q));
endmodule

bind vert_frame_timer vft_checker #(.LINE_W(LINE_W)) u_vft_chk (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .dual_panel(dual_panel),
    .passive_q(passive_q), .lines_q(lines_q), .frame_pulse(frame_pulse),
    .line_valid(line_valid), .line_idx(line_idx), .frame_start(frame_start)
);

// File: tb/test_vert_frame_timer.sv
module test_vert_frame_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_tick = 1'b0;
    logic       passive_mode = 1'b0;
    logic       dual_panel = 1'b0;
    logic [9:0] cfg_lines = '0;
    logic [7:0] cfg_porch = '0;
    logic [5:0] cfg_sync = '0;
    logic       frame_pulse, line_valid, frame_start;
    logic [9:0] line_idx;

    int n_run = 0;
    int n_fail = 0;
    // model state: snapshot and strobes since frame entry
    int m_l, m_p, m_s, m_pas, k;

    always #2 clk = ~clk;

    vert_frame_timer i_vert_frame_timer (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
        .passive_mode(passive_mode), .dual_panel(dual_panel),
        .cfg_lines(cfg_lines), .cfg_porch(cfg_porch), .cfg_sync(cfg_sync),
        .frame_pulse(frame_pulse), .line_valid(line_valid),
        .line_idx(line_idx), .frame_start(frame_start)
    );

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (k=%0d)", tag, act, exp, k);
        end
    endtask

    // 0 active, 1 porch, 2 sync
    function automatic int exp_phase(int kk, int l, int p);
        if (kk <= l) return 0;
        if (kk < l + 1 + p) return 1;
        return 2;
    endfunction

    function automatic int frame_len(int l, int p, int s);
        return l + 1 + p + s + 1;
    endfunction

    task automatic snap();
        m_l = cfg_lines; m_p = cfg_porch; m_s = cfg_sync; m_pas = passive_mode;
    endtask

    task automatic check_outs(string tag, int start_exp);
        int ph;
        ph = exp_phase(k, m_l, m_p);
        chk({tag, " R2 valid"}, line_valid, ph == 0);
        chk({tag, " R2 idx"}, line_idx, (ph == 0) ? k : 0);
        if (m_pas != 0) chk({tag, " R5 pulse"}, frame_pulse, 0);
        else            chk({tag, " R4 pulse"}, frame_pulse, ph == 2);
        chk({tag, " R8 start"}, frame_start, start_exp);
    endtask

    // one strobe, then a gap of idle cycles
    task automatic tick(string tag, int gap);
        int wrapped;
        @(negedge clk) line_tick = 1'b1;
        @(negedge clk) line_tick = 1'b0;
        k++;
        wrapped = 0;
        if (k == frame_len(m_l, m_p, m_s)) begin
            k = 0; wrapped = 1; snap();
        end
        check_outs(tag, wrapped);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            if (g == 0) begin
                chk({tag, " R8 start drop"}, frame_start, 0);
                chk({tag, " R6 idx hold"}, line_idx, (exp_phase(k, m_l, m_p) == 0) ? k : 0);
            end
        end
    endtask

    task automatic run_frames(string tag, int n, int rnd_cfg);
        int done = 0;
        while (done < n) begin
            if (rnd_cfg != 0 && ($urandom % 4) == 0) begin
                cfg_lines = 10'($urandom % 6);
                cfg_porch = 8'($urandom % 4);
                cfg_sync  = 6'($urandom % 3);
                passive_mode = 1'($urandom % 2);
                dual_panel   = 1'($urandom % 2);
            end
            tick(tag, 1 + ($urandom % 3));
            if (k == 0) done++;
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        cfg_lines = 10'd3; cfg_porch = 8'd2; cfg_sync = 6'd1;
        repeat (3) @(negedge clk);
        snap(); k = 0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid", line_valid, 1);
        chk("R1 idx", line_idx, 0);
        chk("R1 pulse", frame_pulse, 0);
        chk("R1 start", frame_start, 0);
        repeat (4) @(negedge clk);
        chk("R6 idle idx", line_idx, 0);
        chk("R6 idle valid", line_valid, 1);

        run_frames("R2 R4 base", 2, 0);
        cfg_porch = 8'd0;
        run_frames("R3 zero porch", 2, 0);
        passive_mode = 1'b1; cfg_sync = 6'd2;
        run_frames("R5 passive", 2, 0);
        passive_mode = 1'b0; dual_panel = 1'b1; cfg_lines = 10'd2;
        run_frames("R9 dual", 2, 0);
        dual_panel = 1'b0; cfg_lines = 10'd0; cfg_porch = 8'd1; cfg_sync = 6'd0;
        run_frames("R2 one line", 2, 0);
        cfg_lines = 10'd1023; cfg_porch = 8'd255; cfg_sync = 6'd63;
        run_frames("R3 max fields", 2, 0);
        // mid-frame rewrites must not affect the running frame
        cfg_lines = 10'd4; cfg_porch = 8'd1; cfg_sync = 6'd1;
        run_frames("R7 reload", 1, 0);
        run_frames("R7 random", 40, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 190000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule